// File: doc/BRIEF.md
# Hybrid Branch Prediction Unit

This block produces the fetch address for the next cycle. Each cycle it receives the current fetch PC. One clock later it presents a predicted next PC and a flag that says whether that prediction is a taken control transfer.

Three structures drive the prediction:
- a small fully associative target buffer, which holds the source address, the target address and the kind of each branch it has seen;
- a table of two-bit saturating direction counters, addressed by the PC combined with a global outcome history;
- a return stack, held both as a speculative copy and as a committed copy.

The execute stage reports every resolved branch through an update port. That report trains the predictor. When the report also carries a redirect, it overrides the prediction and rolls the speculative history and the speculative stack back to their committed values.

A parameter removes prediction entirely. The block then fetches sequentially and follows only resolved redirects.

Top module: `npc_predict`

## Requirements
- R1: During and right after synchronous reset, `next_pc_o` equals RESET_PC (default 0) and `taken_o` is 0. All buffer entries are invalid, every direction counter holds 1, both histories are zero and both stacks are empty.
- R2: Outputs are registered, so the values seen after a clock edge are computed from the fetch PC sampled at that edge. When the fetch PC matches no valid buffer entry and there is no redirect, `next_pc_o` = PC+4 and `taken_o` = 0.
- R3: A buffer hit on an entry of kind jump (1) or call (2) gives `taken_o` = 1 and the stored target. A call hit also pushes PC+4 onto the speculative stack.
- R4: A buffer hit on a conditional entry (kind 0) reads the counter at index PC[9:2] XOR speculative history. The prediction is taken, with the stored target, when the counter is 2 or 3. Otherwise the result is PC+4 with `taken_o` = 0.
- R5: Each conditional hit shifts its predicted outcome into the LSB of the speculative history. Each resolved conditional shifts its actual outcome into the LSB of the committed history. A redirect copies the committed history, including that cycle's update, into the speculative history. The committed history changes only on an update.
- R6: A buffer hit on a return entry (kind 3) is predicted taken. Its target is the top of the speculative stack, which is then popped. If that stack is empty, the stored target is used instead.
- R7: Both stacks are 8 deep, and pushing onto a full stack discards the oldest entry. The committed stack pushes upd_pc+4 on a resolved call and pops on a resolved return. A redirect copies the committed stack, including that cycle's update, into the speculative stack.
- R8: On `upd_valid_i` together with `upd_redirect_i`, the outputs are `upd_target_i` if `upd_taken_i` is set and `upd_pc_i`+4 otherwise, with `taken_o` = 0. No speculative push, pop or history shift takes effect in that cycle.
- R9: A resolved conditional updates the counter at upd_pc[9:2] XOR committed history (the value before the shift), counting up on taken and down otherwise, saturating at 0 and 3. The branch kind is return if `upd_is_ret_i` is set, else call if `upd_is_call_i` is set, else jump if `upd_is_jmp_i` is set, else conditional.
- R10: A resolved update with `upd_taken_i` writes the buffer. If the source address is already present, that entry is rewritten. Otherwise the lowest-index invalid entry is used. If every entry is valid, the entry chosen is the low 3 bits of a 16-bit LFSR.
- R11: The LFSR is seeded with 0xACE1 at reset. It advances on every clock outside reset by shifting left and inserting bit15^bit13^bit12^bit10 at bit 0. The victim is taken from its value before the edge.
- R12: With PREDICT_EN = 0, `next_pc_o` is PC+4 with `taken_o` = 0, except that a redirect follows the R8 rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc_i | input | ADDR_W | Current fetch address |
| upd_valid_i | input | 1 | A resolved branch is reported |
| upd_redirect_i | input | 1 | The resolution disagrees with the prediction; fetch restarts |
| upd_taken_i | input | 1 | Resolved branch was taken |
| upd_pc_i | input | ADDR_W | Address of the resolved branch |
| upd_target_i | input | ADDR_W | Resolved target address |
| upd_is_call_i | input | 1 | Resolved branch is a call |
| upd_is_ret_i | input | 1 | Resolved branch is a return |
| upd_is_jmp_i | input | 1 | Resolved branch is an unconditional jump |
| next_pc_o | output | ADDR_W | Predicted next fetch address (registered) |
| taken_o | output | 1 | Prediction is a taken transfer (registered) |

## Verification
The patterns used, and what each one separates:
- **Sequential addresses on an empty buffer** separate the miss path from the hit path.
- **A trained jump, and a conditional trained through its counter states**, show the hysteresis of the counters and the effect of history on indexing.
- **Nested calls followed by returns, including more calls than the stack holds**, distinguish stack-supplied targets from buffer targets and expose the discard-oldest behaviour.
- **Filling the buffer past capacity** forces LFSR victim choice.
- **A long random mix of updates with interleaved redirects** checks history and stack rollback against an independent behavioural model.
- **A second instance with prediction disabled** is held to the sequential rule.

// File: rtl/npc_predict_pkg.sv
package npc_predict_pkg;

  typedef enum logic [1:0] {
    BK_COND = 2'd0,
    BK_JUMP = 2'd1,
    BK_CALL = 2'd2,
    BK_RET  = 2'd3
  } br_kind_e;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;

  function automatic br_kind_e classify(input logic is_ret, input logic is_call,
                                        input logic is_jmp);
    if (is_ret)       return BK_RET;
    else if (is_call) return BK_CALL;
    else if (is_jmp)  return BK_JUMP;
    else              return BK_COND;
  endfunction

  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/npc_btb.sv
module npc_btb
  import npc_predict_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int AW      = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] lk_pc,
  output logic          lk_hit,
  output br_kind_e      lk_kind,
  output logic [AW-1:0] lk_tgt,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_src,
  input  logic [AW-1:0] wr_tgt,
  input  br_kind_e      wr_kind
);
  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld;
  logic [AW-1:0]      src_q [ENTRIES];
  logic [AW-1:0]      tgt_q [ENTRIES];
  br_kind_e           kind_q[ENTRIES];
  logic [15:0]        lfsr;

  logic [ENTRIES-1:0] lk_match, wr_match;
  logic [IW-1:0]      lk_idx, wr_idx, free_idx, sel_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = vld[g] && (src_q[g] == lk_pc);
    assign wr_match[g] = vld[g] && (src_q[g] == wr_src);
  end

  // lowest index wins in every encoder
  always_comb begin
    lk_idx   = '0;
    wr_idx   = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i]) lk_idx   = IW'(i);
      if (wr_match[i]) wr_idx   = IW'(i);
      if (!vld[i])     free_idx = IW'(i);
    end
  end

  always_comb begin
    if (|wr_match)     sel_idx = wr_idx;
    else if (!(&vld))  sel_idx = free_idx;
    else               sel_idx = lfsr[IW-1:0];
  end

  assign lk_hit  = |lk_match;
  assign lk_kind = kind_q[lk_idx];
  assign lk_tgt  = tgt_q[lk_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= '0;
      lfsr <= LFSR_SEED;
    end else begin
      lfsr <= lfsr_step(lfsr);
      if (wr_en) vld[sel_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      src_q[sel_idx]  <= wr_src;
      tgt_q[sel_idx]  <= wr_tgt;
      kind_q[sel_idx] <= wr_kind;
    end
  end

endmodule

// File: rtl/npc_dir.sv
module npc_dir #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_bits,
  output logic             rd_taken,
  input  logic             spec_shift,
  input  logic             spec_bit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_bits,
  input  logic             wr_taken,
  input  logic             restore,
  output logic [IDX_W-1:0] ghr_spec_o,
  output logic [IDX_W-1:0] ghr_com_o
);
  localparam int N = 2 ** IDX_W;

  logic [1:0]       ctr [N];
  logic [IDX_W-1:0] ghs, ghc, ghc_n, rd_idx, wr_idx;
  logic [1:0]       old_c, new_c;

  assign rd_idx   = rd_bits ^ ghs;
  assign wr_idx   = wr_bits ^ ghc;
  assign rd_taken = ctr[rd_idx][1];
  assign old_c    = ctr[wr_idx];

  always_comb begin
    new_c = old_c;
    if (wr_taken && old_c != 2'd3)       new_c = old_c + 2'd1;
    else if (!wr_taken && old_c != 2'd0) new_c = old_c - 2'd1;
  end

  assign ghc_n = wr_en ? {ghc[IDX_W-2:0], wr_taken} : ghc;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) ctr[i] <= 2'd1;
      ghs <= '0;
      ghc <= '0;
    end else begin
      if (wr_en) ctr[wr_idx] <= new_c;
      ghc <= ghc_n;
      if (restore)         ghs <= ghc_n;
      else if (spec_shift) ghs <= {ghs[IDX_W-2:0], spec_bit};
    end
  end

  assign ghr_spec_o = ghs;
  assign ghr_com_o  = ghc;

endmodule

// File: rtl/npc_ras.sv
module npc_ras #(
  parameter int DEPTH = 8,
  parameter int AW    = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       spec_push,
  input  logic                       spec_pop,
  input  logic [AW-1:0]              spec_val,
  input  logic                       com_push,
  input  logic                       com_pop,
  input  logic [AW-1:0]              com_val,
  input  logic                       restore,
  output logic [AW-1:0]              spec_top,
  output logic                       spec_empty,
  output logic [$clog2(DEPTH):0]     spec_cnt_o,
  output logic [$clog2(DEPTH):0]     com_cnt_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] spec_mem[DEPTH];
  logic [AW-1:0] com_mem [DEPTH];
  logic [PW-1:0] spec_ptr, com_ptr, com_ptr_n;
  logic [CW-1:0] spec_cnt, com_cnt, com_cnt_n;

  always_comb begin
    com_ptr_n = com_ptr;
    com_cnt_n = com_cnt;
    if (com_push) begin
      com_ptr_n = com_ptr + PW'(1);
      com_cnt_n = (com_cnt == FULL) ? FULL : com_cnt + CW'(1);
    end else if (com_pop && com_cnt != '0) begin
      com_ptr_n = com_ptr - PW'(1);
      com_cnt_n = com_cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      com_ptr  <= '0;
      com_cnt  <= '0;
      spec_ptr <= '0;
      spec_cnt <= '0;
    end else begin
      com_ptr <= com_ptr_n;
      com_cnt <= com_cnt_n;
      if (restore) begin
        spec_ptr <= com_ptr_n;
        spec_cnt <= com_cnt_n;
      end else if (spec_push) begin
        spec_ptr <= spec_ptr + PW'(1);
        spec_cnt <= (spec_cnt == FULL) ? FULL : spec_cnt + CW'(1);
      end else if (spec_pop && spec_cnt != '0) begin
        spec_ptr <= spec_ptr - PW'(1);
        spec_cnt <= spec_cnt - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (com_push) com_mem[com_ptr_n] <= com_val;
    if (restore) begin
      for (int i = 0; i < DEPTH; i++)
        spec_mem[i] <= (com_push && PW'(i) == com_ptr_n) ? com_val : com_mem[i];
    end else if (spec_push) begin
      spec_mem[spec_ptr + PW'(1)] <= spec_val;
    end
  end

  assign spec_top   = spec_mem[spec_ptr];
  assign spec_empty = (spec_cnt == '0);
  assign spec_cnt_o = spec_cnt;
  assign com_cnt_o  = com_cnt;

endmodule

// File: rtl/npc_predict.sv
module npc_predict
  import npc_predict_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          BTB_ENTRIES = 8,
  parameter int          PHT_IDX_W   = 8,
  parameter int          RAS_DEPTH   = 8,
  parameter bit          PREDICT_EN  = 1'b1,
  parameter logic [31:0] RESET_PC    = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  input  logic              upd_valid_i,
  input  logic              upd_redirect_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic              upd_is_call_i,
  input  logic              upd_is_ret_i,
  input  logic              upd_is_jmp_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              taken_o
);
  localparam int CNT_W = $clog2(RAS_DEPTH) + 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic              redirect;
  logic [ADDR_W-1:0] seq_pc, fix_pc, pred_pc, nxt_pc;
  logic              pred_tk, nxt_tk;
  logic [PHT_IDX_W-1:0] ghr_spec, ghr_com;
  logic [CNT_W-1:0]     ras_spec_cnt, ras_com_cnt;

  assign redirect = upd_valid_i && upd_redirect_i;
  assign seq_pc   = fetch_pc_i + STEP;
  assign fix_pc   = upd_taken_i ? upd_target_i : upd_pc_i + STEP;

  if (PREDICT_EN) begin : g_pred
    br_kind_e          hit_kind, upd_kind;
    logic              hit, dir_tk, ras_empty, use_ras;
    logic [ADDR_W-1:0] hit_tgt, ras_top;

    assign upd_kind = classify(upd_is_ret_i, upd_is_call_i, upd_is_jmp_i);

    npc_btb #(.ENTRIES(BTB_ENTRIES), .AW(ADDR_W)) u_btb (
      .clk    (clk),
      .rst    (rst),
      .lk_pc  (fetch_pc_i),
      .lk_hit (hit),
      .lk_kind(hit_kind),
      .lk_tgt (hit_tgt),
      .wr_en  (upd_valid_i && upd_taken_i),
      .wr_src (upd_pc_i),
      .wr_tgt (upd_target_i),
      .wr_kind(upd_kind)
    );

    npc_dir #(.IDX_W(PHT_IDX_W)) u_dir (
      .clk       (clk),
      .rst       (rst),
      .rd_bits   (fetch_pc_i[2 +: PHT_IDX_W]),
      .rd_taken  (dir_tk),
      .spec_shift(!redirect && hit && hit_kind == BK_COND),
      .spec_bit  (dir_tk),
      .wr_en     (upd_valid_i && upd_kind == BK_COND),
      .wr_bits   (upd_pc_i[2 +: PHT_IDX_W]),
      .wr_taken  (upd_taken_i),
      .restore   (redirect),
      .ghr_spec_o(ghr_spec),
      .ghr_com_o (ghr_com)
    );

    npc_ras #(.DEPTH(RAS_DEPTH), .AW(ADDR_W)) u_ras (
      .clk       (clk),
      .rst       (rst),
      .spec_push (!redirect && hit && hit_kind == BK_CALL),
      .spec_pop  (!redirect && hit && hit_kind == BK_RET),
      .spec_val  (seq_pc),
      .com_push  (upd_valid_i && upd_kind == BK_CALL),
      .com_pop   (upd_valid_i && upd_kind == BK_RET),
      .com_val   (upd_pc_i + STEP),
      .restore   (redirect),
      .spec_top  (ras_top),
      .spec_empty(ras_empty),
      .spec_cnt_o(ras_spec_cnt),
      .com_cnt_o (ras_com_cnt)
    );

    assign use_ras = (hit_kind == BK_RET) && !ras_empty;
    assign pred_tk = hit && (hit_kind != BK_COND || dir_tk);
    assign pred_pc = !pred_tk ? seq_pc : (use_ras ? ras_top : hit_tgt);
  end else begin : g_seq
    assign pred_tk      = 1'b0;
    assign pred_pc      = seq_pc;
    assign ghr_spec     = '0;
    assign ghr_com      = '0;
    assign ras_spec_cnt = '0;
    assign ras_com_cnt  = '0;
  end

  assign nxt_pc = redirect ? fix_pc : pred_pc;
  assign nxt_tk = !redirect && pred_tk;

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc_o <= RESET_PC[ADDR_W-1:0];
      taken_o   <= 1'b0;
    end else begin
      next_pc_o <= nxt_pc;
      taken_o   <= nxt_tk;
    end
  end

endmodule

// File: rtl/npc_predict_chk.sv
module npc_predict_chk #(
  parameter int AW    = 32,
  parameter int HW    = 8,
  parameter int CW    = 4,
  parameter int DEPTH = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] fetch_pc_i,
  input logic          upd_valid_i,
  input logic          upd_redirect_i,
  input logic          upd_taken_i,
  input logic [AW-1:0] upd_pc_i,
  input logic [AW-1:0] upd_target_i,
  input logic [AW-1:0] next_pc_o,
  input logic          taken_o,
  input logic [HW-1:0] ghr_spec,
  input logic [HW-1:0] ghr_com,
  input logic [CW-1:0] ras_spec_cnt,
  input logic [CW-1:0] ras_com_cnt
);
  logic fix;
  assign fix = upd_valid_i && upd_redirect_i;

  p_redirect_target_r8: assert property (@(posedge clk) disable iff (rst)
    fix |=> (!taken_o && next_pc_o == ($past(upd_taken_i) ? $past(upd_target_i)
                                                          : $past(upd_pc_i) + AW'(4))));

  p_seq_when_not_taken_r2: assert property (@(posedge clk) disable iff (rst)
    !fix |=> (taken_o || next_pc_o == $past(fetch_pc_i) + AW'(4)));

  p_hist_restore_r5: assert property (@(posedge clk) disable iff (rst)
    fix |=> (ghr_spec == ghr_com));

  p_hist_commit_stable_r5: assert property (@(posedge clk) disable iff (rst)
    !upd_valid_i |=> $stable(ghr_com));

  p_stack_restore_r7: assert property (@(posedge clk) disable iff (rst)
    fix |=> (ras_spec_cnt == ras_com_cnt));

  p_stack_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (ras_spec_cnt <= CW'(DEPTH)) && (ras_com_cnt <= CW'(DEPTH)));

endmodule

bind npc_predict npc_predict_chk #(
  .AW(ADDR_W), .HW(PHT_IDX_W), .CW($clog2(RAS_DEPTH) + 1), .DEPTH(RAS_DEPTH)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .fetch_pc_i    (fetch_pc_i),
  .upd_valid_i   (upd_valid_i),
  .upd_redirect_i(upd_redirect_i),
  .upd_taken_i   (upd_taken_i),
  .upd_pc_i      (upd_pc_i),
  .upd_target_i  (upd_target_i),
  .next_pc_o     (next_pc_o),
  .taken_o       (taken_o),
  .ghr_spec      (ghr_spec),
  .ghr_com       (ghr_com),
  .ras_spec_cnt  (ras_spec_cnt),
  .ras_com_cnt   (ras_com_cnt)
);

// File: tb/test_npc_predict.sv
`timescale 1ns/1ps
module test_npc_predict;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_pc = 32'h0;
  logic        uv = 1'b0, ur = 1'b0, ut = 1'b0, ucall = 1'b0, uret = 1'b0, ujmp = 1'b0;
  logic [31:0] upc = 32'h0, utgt = 32'h0;
  logic [31:0] npc_a, npc_b;
  logic        tk_a, tk_b;

  always #5 clk = ~clk;

  npc_predict i_npc_predict (
    .clk(clk), .rst(rst), .fetch_pc_i(fetch_pc), .upd_valid_i(uv), .upd_redirect_i(ur),
    .upd_taken_i(ut), .upd_pc_i(upc), .upd_target_i(utgt), .upd_is_call_i(ucall),
    .upd_is_ret_i(uret), .upd_is_jmp_i(ujmp), .next_pc_o(npc_a), .taken_o(tk_a));

  npc_predict #(.PREDICT_EN(1'b0)) i_npc_predict_off (
    .clk(clk), .rst(rst), .fetch_pc_i(fetch_pc), .upd_valid_i(uv), .upd_redirect_i(ur),
    .upd_taken_i(ut), .upd_pc_i(upc), .upd_target_i(utgt), .upd_is_call_i(ucall),
    .upd_is_ret_i(uret), .upd_is_jmp_i(ujmp), .next_pc_o(npc_b), .taken_o(tk_b));

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  string scn = "R1";

  // behavioural reference model
  bit          mv[8];
  logic [31:0] ms[8], mt[8];
  int          mk[8];
  int          ctr[256];
  logic [7:0]  ghs, ghc;
  logic [31:0] sq[$], cq[$];
  logic [15:0] lf;
  logic [31:0] exp_a, exp_b;
  bit          etk_a, etk_b, have_exp = 1'b0;
  string       why;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) mv[i] = 1'b0;
      for (int i = 0; i < 256; i++) ctr[i] = 1;
      ghs = 8'h0; ghc = 8'h0; sq.delete(); cq.delete(); lf = 16'hACE1;
      exp_a = 32'h0; exp_b = 32'h0; etk_a = 1'b0; etk_b = 1'b0; why = "R1";
    end else begin
      bit fix;
      int hit, uk, w;
      fix = uv && ur;
      hit = -1;
      for (int i = 0; i < 8; i++) if (hit < 0 && mv[i] && ms[i] == fetch_pc) hit = i;
      uk = uret ? 3 : (ucall ? 2 : (ujmp ? 1 : 0));
      exp_b = fix ? (ut ? utgt : upc + 32'd4) : fetch_pc + 32'd4;
      etk_b = 1'b0;
      if (fix) begin
        exp_a = exp_b; etk_a = 1'b0; why = "R8";
      end else if (hit < 0) begin
        exp_a = fetch_pc + 32'd4; etk_a = 1'b0; why = "R2";
      end else if (mk[hit] == 0) begin
        bit t;
        t = ctr[fetch_pc[9:2] ^ ghs] >= 2;
        exp_a = t ? mt[hit] : fetch_pc + 32'd4; etk_a = t; why = "R4";
        ghs = {ghs[6:0], t};
      end else if (mk[hit] == 3) begin
        etk_a = 1'b1; why = "R6";
        if (sq.size() > 0) exp_a = sq.pop_back(); else exp_a = mt[hit];
      end else begin
        exp_a = mt[hit]; etk_a = 1'b1; why = "R3";
        if (mk[hit] == 2) begin
          sq.push_back(fetch_pc + 32'd4);
          if (sq.size() > 8) void'(sq.pop_front());
        end
      end
      if (uv) begin
        if (uk == 0) begin
          w = int'(upc[9:2] ^ ghc);
          if (ut && ctr[w] < 3) ctr[w]++;
          if (!ut && ctr[w] > 0) ctr[w]--;
          ghc = {ghc[6:0], ut};
        end else if (uk == 2) begin
          cq.push_back(upc + 32'd4);
          if (cq.size() > 8) void'(cq.pop_front());
        end else if (uk == 3) begin
          if (cq.size() > 0) void'(cq.pop_back());
        end
        if (ut) begin
          int sel;
          sel = -1;
          for (int i = 0; i < 8; i++) if (sel < 0 && mv[i] && ms[i] == upc) sel = i;
          for (int i = 0; i < 8; i++) if (sel < 0 && !mv[i]) sel = i;
          if (sel < 0) sel = int'(lf[2:0]);
          mv[sel] = 1'b1; ms[sel] = upc; mt[sel] = utgt; mk[sel] = uk;
        end
      end
      if (fix) begin
        ghs = ghc; sq = cq;
      end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    end
    have_exp = 1'b1;
  end

  always @(negedge clk) begin
    if (have_exp && !done) begin
      checks++;
      if (npc_a !== exp_a || tk_a !== etk_a) begin
        errors++;
        $display("FAIL %s [%s] pc=%h: next_pc=%h taken=%0b expected %h %0b",
                 why, scn, fetch_pc, npc_a, tk_a, exp_a, etk_a);
      end
      checks++;
      if (npc_b !== exp_b || tk_b !== etk_b) begin
        errors++;
        $display("FAIL R12 [%s] pc=%h: next_pc=%h taken=%0b expected %h %0b",
                 scn, fetch_pc, npc_b, tk_b, exp_b, etk_b);
      end
    end
  end

  task automatic cyc(input logic [31:0] pc);
    fetch_pc = pc; uv = 0; ur = 0; ut = 0; ucall = 0; uret = 0; ujmp = 0;
    @(negedge clk);
  endtask

  task automatic upd(input logic [31:0] pc, input logic [31:0] src, input logic [31:0] tgt,
                     input bit taken, input bit fix, input int kind);
    fetch_pc = pc; uv = 1; ur = fix; ut = taken; upc = src; utgt = tgt;
    uret = (kind == 3); ucall = (kind == 2); ujmp = (kind == 1);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    scn = "R2";
    for (int i = 0; i < 20; i++) cyc(32'h1000 + 32'(i * 4));
    scn = "R3";
    upd(32'h50, 32'h100, 32'h400, 1, 0, 1);
    for (int i = 0; i < 3; i++) cyc(32'h100);
    scn = "R4 R5 R9";
    for (int r = 0; r < 4; r++) begin
      upd(32'h60, 32'h200, 32'h600, 1, 0, 0);
      cyc(32'h200); cyc(32'h204);
    end
    for (int r = 0; r < 4; r++) begin
      upd(32'h60, 32'h200, 32'h600, 0, 0, 0);
      cyc(32'h200);
    end
    scn = "R6 R7";
    upd(32'h70, 32'h300, 32'h800, 1, 0, 2);
    upd(32'h70, 32'h900, 32'h304, 1, 0, 3);
    cyc(32'h300); cyc(32'h900); cyc(32'h900);
    for (int i = 0; i < 11; i++) cyc(32'h300);
    for (int i = 0; i < 11; i++) cyc(32'h900);
    scn = "R7 R8";
    for (int i = 0; i < 5; i++) upd(32'h300, 32'h300, 32'h800, 1, 0, 2);
    for (int i = 0; i < 3; i++) cyc(32'h300);
    upd(32'h300, 32'h204, 32'h0, 0, 1, 0);
    for (int i = 0; i < 7; i++) cyc(32'h900);
    scn = "R10 R11";
    for (int i = 0; i < 12; i++) upd(32'h40, 32'h2000 + 32'(i * 16), 32'h3000 + 32'(i * 8), 1, 0, 1);
    for (int i = 0; i < 12; i++) cyc(32'h2000 + 32'(i * 16));
    scn = "R5 R7 R10 random";
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] pcs[8];
      logic [31:0] p, s;
      int k;
      pcs = '{32'h100, 32'h200, 32'h300, 32'h900, 32'h2000, 32'h2010, 32'h2400, 32'h2404};
      p = pcs[$urandom_range(7)];
      if ($urandom_range(9) < 4) begin
        s = pcs[$urandom_range(7)];
        k = $urandom_range(3);
        upd(p, s, 32'h4000 + 32'($urandom_range(255) * 4),
            (k != 0) || ($urandom_range(1) == 1), $urandom_range(6) == 0, k);
      end else begin
        cyc(p);
      end
    end
    cyc(32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule